// File: doc/BRIEF.md
# I/O Readiness Trap and Break-In Unit

This unit sits beside an instruction sequencer and makes input/output instructions non-blocking. A decoded I/O request names a device and carries an address field. If the named device is ready, the transfer goes ahead. If it is not ready, the unit sends control to the address field instead, and the program never stalls.

The unit also turns device readiness into a break-in. A rising edge on any device-ready line is held as pending. At the next instruction boundary, the unit writes the sequencer's next address into the save word, which is the second-highest address. In the cycle after that write, it redirects control to the vector word, which is the highest address, and pulses an acknowledge. Only one break-in is taken at a time. A mask stays set from the moment a break-in is accepted until the handler signals its return jump.

Top module: `iotrap_brk`

## Requirements
- R1: After a synchronous reset, `redir_valid`, `io_xfer`, `mem_we` and `brk_ack` are 0, no event is pending and break-ins are unmasked.
- R2: When `io_req` is 1 and `dev_ready[io_dev]` is 0, the next cycle shows `redir_valid`=1 with `redir_addr`=`io_target` and `io_xfer`=0.
- R3: When `io_req` is 1 and `dev_ready[io_dev]` is 1, the next cycle shows `io_xfer`=1 and `redir_valid`=0.
- R4: A rising edge on any `dev_ready` bit is held as pending, even if the line falls again one cycle later. A line that is already high in the first cycle after reset counts as a rising edge.
- R5: A break-in is accepted only in a cycle with `boundary`=1, an event pending and the mask clear. Without `boundary`, a pending event causes no memory write.
- R6: In the cycle after a break-in is accepted, `mem_we`=1, `mem_waddr`=2^ADDR_W-2 (510) and `mem_wdata` equals the `next_addr` that was present in the accepting cycle.
- R7: In the cycle after the write, `redir_valid`=1, `redir_addr`=2^ADDR_W-1 (511) and `brk_ack`=1, while `mem_we`=0. The write therefore always comes before the fetch from the vector.
- R8: Any number of simultaneous rising edges produces exactly one break-in. All pending events are cleared when the break-in is accepted.
- R9: From acceptance until `handler_ret`=1 (sampled while no break-in is in progress), boundaries take no break-in. Events arriving in that window stay pending and are taken at the first boundary after the return.
- R10: An `io_req` presented in the accepting cycle, or in the write cycle, causes no redirect of its own and no transfer. The redirect that follows the write still goes to 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Decoded I/O instruction strobe |
| io_dev | input | DEV_W | Device addressed by the I/O instruction |
| io_target | input | ADDR_W | Address field of the I/O instruction (fallback jump) |
| dev_ready | input | N_DEV | Device ready levels (inputs and outputs alike) |
| next_addr | input | ADDR_W | Address the sequencer would run next |
| boundary | input | 1 | Instruction boundary strobe |
| handler_ret | input | 1 | Handler executed its return jump; clears the mask |
| redir_valid | output | 1 | Redirect the sequencer this cycle |
| redir_addr | output | ADDR_W | Redirect target |
| io_xfer | output | 1 | Transfer of the requested I/O instruction proceeds |
| mem_we | output | 1 | Memory write request for the return address |
| mem_waddr | output | ADDR_W | Memory write address (save word) |
| mem_wdata | output | ADDR_W | Saved return address |
| brk_ack | output | 1 | Break-in acknowledged; vector fetch issued |

## Verification
The hardest situations to reach are the collisions. One is an I/O request landing in the accepting cycle or the write cycle of a break-in. Another is a ready edge that arrives while the mask is set and must survive until after the return. The bench builds each one explicitly. It first plants a pending event with a one-cycle ready pulse, then raises `boundary` together with `io_req`, or issues `io_req` exactly one cycle later. For the masked case, it pulses a second device inside the handler window, offers a boundary that must be refused, then returns and expects a second save and vector. Every non-empty pattern of simultaneous edges on the four lines is swept, as is every device-and-readiness combination for the trap path.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_SAVE = 2'd1,
        BK_VEC  = 2'd2
    } bk_state_e;

    typedef struct packed {
        logic valid;
        logic xfer;
    } trap_flags_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/iotrap_pend.sv
module iotrap_pend #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] ready,
    input  logic             clr,
    output logic             pend_any
);
    logic [N_DEV-1:0] prev_q;
    logic [N_DEV-1:0] pend_q;
    logic [N_DEV-1:0] rise;

    assign rise = ready & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= ready;
            pend_q <= (clr ? '0 : pend_q) | rise;
        end
    end

    assign pend_any = |pend_q;

    a_r4_edge_held: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> pend_any);

endmodule

// File: rtl/iotrap_seq.sv
module iotrap_seq
    import iotrap_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              pend_any,
    input  logic              handler_ret,
    input  logic [ADDR_W-1:0] next_addr,
    output logic              take,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              vec_valid
);
    localparam logic [ADDR_W-1:0] SAVE_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};

    bk_state_e         state_q;
    logic              mask_q;
    logic [ADDR_W-1:0] ret_q;

    assign take = boundary && pend_any && !mask_q && (state_q == BK_IDLE);
    assign busy = take || (state_q == BK_SAVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
            mask_q  <= 1'b0;
            ret_q   <= '0;
        end else begin
            unique case (state_q)
                BK_IDLE: if (take) begin
                    state_q <= BK_SAVE;
                    ret_q   <= next_addr;
                end
                BK_SAVE: state_q <= BK_VEC;
                default: state_q <= BK_IDLE;
            endcase
            if (take)
                mask_q <= 1'b1;
            else if (handler_ret && state_q == BK_IDLE)
                mask_q <= 1'b0;
        end
    end

    assign mem_we    = (state_q == BK_SAVE);
    assign mem_waddr = SAVE_ADDR;
    assign mem_wdata = ret_q;
    assign vec_valid = (state_q == BK_VEC);

    a_r5_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(boundary));
    a_r6_saved_addr: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_wdata == $past(next_addr));
    a_r7_vec_follows_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> vec_valid && !mem_we);
    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !mem_we);

endmodule

// File: rtl/iotrap_redir.sv
module iotrap_redir
    import iotrap_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int N_DEV  = 4,
    localparam int DEV_W = idx_width(N_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic [DEV_W-1:0]  io_dev,
    input  logic [ADDR_W-1:0] io_target,
    input  logic [N_DEV-1:0]  ready,
    input  logic              block,
    input  logic              vec_valid,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              io_xfer
);
    localparam logic [ADDR_W-1:0] VEC_ADDR = {ADDR_W{1'b1}};

    trap_flags_t       fl_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              dev_rdy;

    assign dev_rdy = (int'(io_dev) < N_DEV) ? ready[io_dev] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q  <= '0;
            tgt_q <= '0;
        end else begin
            fl_q.valid <= io_req && !block && !dev_rdy;
            fl_q.xfer  <= io_req && !block && dev_rdy;
            tgt_q      <= io_target;
        end
    end

    assign redir_valid = vec_valid || fl_q.valid;
    assign redir_addr  = vec_valid ? VEC_ADDR : tgt_q;
    assign io_xfer     = fl_q.xfer;

    a_r2_trap_from_request: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !vec_valid) |-> $past(io_req) && !$past(block));
    a_r3_xfer_from_request: assert property (@(posedge clk) disable iff (rst)
        io_xfer |-> $past(io_req) && !redir_valid);
    a_r10_no_trap_on_vector: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !io_xfer);

endmodule

// File: rtl/iotrap_brk.sv
module iotrap_brk
    import iotrap_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int N_DEV  = 4,
    localparam int DEV_W = idx_width(N_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic [DEV_W-1:0]  io_dev,
    input  logic [ADDR_W-1:0] io_target,
    input  logic [N_DEV-1:0]  dev_ready,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              boundary,
    input  logic              handler_ret,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              io_xfer,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              brk_ack
);
    logic pend_any;
    logic take;
    logic busy;
    logic vec_valid;

    iotrap_pend #(.N_DEV(N_DEV)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .ready    (dev_ready),
        .clr      (take),
        .pend_any (pend_any)
    );

    iotrap_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .boundary    (boundary),
        .pend_any    (pend_any),
        .handler_ret (handler_ret),
        .next_addr   (next_addr),
        .take        (take),
        .busy        (busy),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .vec_valid   (vec_valid)
    );

    iotrap_redir #(.ADDR_W(ADDR_W), .N_DEV(N_DEV)) u_redir (
        .clk         (clk),
        .rst         (rst),
        .io_req      (io_req),
        .io_dev      (io_dev),
        .io_target   (io_target),
        .ready       (dev_ready),
        .block       (busy),
        .vec_valid   (vec_valid),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .io_xfer     (io_xfer)
    );

    assign brk_ack = vec_valid;

    a_r8_pending_before_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(pend_any));
    a_r7_ack_after_write: assert property (@(posedge clk) disable iff (rst)
        brk_ack |-> $past(mem_we) && redir_valid);

endmodule

// File: tb/iotrap_brk_bench.sv
module iotrap_brk_bench;
    localparam int ADDR_W = 9;
    localparam int N_DEV  = 4;
    localparam int DEV_W  = 2;
    localparam int SAVE_A = (1 << ADDR_W) - 2;
    localparam int VEC_A  = (1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              io_req = 1'b0;
    logic [DEV_W-1:0]  io_dev = '0;
    logic [ADDR_W-1:0] io_target = '0;
    logic [N_DEV-1:0]  dev_ready = '0;
    logic [ADDR_W-1:0] next_addr = '0;
    logic              boundary = 1'b0;
    logic              handler_ret = 1'b0;
    logic              redir_valid;
    logic [ADDR_W-1:0] redir_addr;
    logic              io_xfer;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_wdata;
    logic              brk_ack;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    iotrap_brk #(.ADDR_W(ADDR_W), .N_DEV(N_DEV)) u_iotrap_brk (
        .clk(clk), .rst(rst), .io_req(io_req), .io_dev(io_dev),
        .io_target(io_target), .dev_ready(dev_ready), .next_addr(next_addr),
        .boundary(boundary), .handler_ret(handler_ret),
        .redir_valid(redir_valid), .redir_addr(redir_addr), .io_xfer(io_xfer),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .brk_ack(brk_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; io_req = 0; boundary = 0; handler_ret = 0; dev_ready = '0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic quiet(input string req);
        check({req, " mem_we idle"}, int'(mem_we), 0);
        check({req, " redir idle"}, int'(redir_valid), 0);
        check({req, " ack idle"}, int'(brk_ack), 0);
    endtask

    // boundary with pending event: write cycle then vector cycle (R6, R7)
    task automatic expect_breakin(input int ret);
        next_addr = ADDR_W'(ret); boundary = 1;
        step();
        boundary = 0;
        check("R6 mem_we", int'(mem_we), 1);
        check("R6 waddr", int'(mem_waddr), SAVE_A);
        check("R6 wdata", int'(mem_wdata), ret);
        check("R7 no redirect during write", int'(redir_valid), 0);
        step();
        check("R7 redir_valid", int'(redir_valid), 1);
        check("R7 redir_addr", int'(redir_addr), VEC_A);
        check("R7 ack", int'(brk_ack), 1);
        check("R7 write done", int'(mem_we), 0);
        step();
        quiet("R8 single break-in");
    endtask

    task automatic offer_boundary_none(input string req);
        boundary = 1;
        step();
        boundary = 0;
        check({req, " no write"}, int'(mem_we), 0);
        step();
        check({req, " no ack"}, int'(brk_ack), 0);
    endtask

    task automatic pulse_dev(input int d);
        dev_ready = N_DEV'(1 << d);
        step();
        dev_ready = '0;
        step();
    endtask

    initial begin
        do_reset();
        // R1
        quiet("R1");
        check("R1 xfer", int'(io_xfer), 0);
        offer_boundary_none("R1 nothing pending");

        // R2 / R3: every device against every readiness pattern
        for (int d = 0; d < N_DEV; d++) begin
            for (int p = 0; p < (1 << N_DEV); p++) begin
                dev_ready = N_DEV'(p); io_dev = DEV_W'(d);
                io_target = ADDR_W'(37 * d + p + 1); io_req = 1;
                step();
                io_req = 0;
                if (((p >> d) & 1) == 0) begin
                    check("R2 trap redirect", int'(redir_valid), 1);
                    check("R2 trap target", int'(redir_addr), 37 * d + p + 1);
                    check("R2 no xfer", int'(io_xfer), 0);
                end else begin
                    check("R3 xfer", int'(io_xfer), 1);
                    check("R3 no redirect", int'(redir_valid), 0);
                end
                dev_ready = '0;
                step();
            end
        end

        // R4 / R5: short pulse held, no break-in without boundary
        do_reset();
        pulse_dev(2);
        for (int k = 0; k < 5; k++) begin
            step();
            check("R5 no write without boundary", int'(mem_we), 0);
        end
        expect_breakin(123);           // R4 pulse was held
        // R9 masked: new event waits for return
        pulse_dev(1);
        offer_boundary_none("R9 masked");
        offer_boundary_none("R9 still masked");
        handler_ret = 1; step(); handler_ret = 0;
        expect_breakin(77);
        handler_ret = 1; step(); handler_ret = 0;
        offer_boundary_none("R8 cleared");

        // R8: every simultaneous pattern gives one break-in
        for (int p = 1; p < (1 << N_DEV); p++) begin
            do_reset();
            dev_ready = N_DEV'(p); step(); dev_ready = '0; step();
            expect_breakin(p * 29);
            handler_ret = 1; step(); handler_ret = 0;
            offer_boundary_none("R8 one break-in per burst");
        end

        // R10: io_req in accepting cycle, then in write cycle
        do_reset();
        pulse_dev(0);
        io_dev = 2'd3; io_target = 9'd40; io_req = 1;
        next_addr = 9'd200; boundary = 1;
        step();
        boundary = 0;
        check("R10 write", int'(mem_we), 1);
        check("R10 no trap in take cycle", int'(redir_valid), 0);
        check("R10 no xfer in take cycle", int'(io_xfer), 0);
        dev_ready = 4'b1000; io_target = 9'd41;   // ready device, write cycle
        step();
        io_req = 0;
        check("R10 vector kept", int'(redir_addr), VEC_A);
        check("R10 ack", int'(brk_ack), 1);
        check("R10 no xfer in write cycle", int'(io_xfer), 0);
        dev_ready = '0;
        step();
        check("R10 no late redirect", int'(redir_valid), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule